// File: doc/BRIEF.md
# Interrupt Stack Frame Builder

This block carries out the stack part of delivering an interrupt or exception in 64-bit mode. The gate has already been checked elsewhere. A request supplies three things: the gate's target code selector, the gate's target offset, and the gate's lowest type bit. The type bit tells a trap gate from an interrupt gate. The request also carries a snapshot of the current architectural state: return RIP, CS, SS, RSP and RFLAGS. Finally it carries two stack-switch indicators, an interrupt-stack-table index and a privilege-change bit.

The block first lowers RSP by 40 bytes and aligns it down to 16 bytes. It then probes the first and last quadword of the new frame through a memory request channel. Only after both probes return without fault does it write the five frame quadwords. After the last write is accepted, it presents the new register values for one cycle. A done pulse follows one cycle later.

Any request that would need a stack switch is refused with an unsupported-condition pulse. A faulting probe abandons the sequence before any write or register update.

The request and memory channels are valid/ready. The request payload is captured in the cycle where `req_valid` and `req_ready` are both high. A memory request, once raised, keeps its kind, address and data unchanged until `mem_ready` accepts it. A write is complete at acceptance. A probe is complete when `rsp_valid` returns, carrying `rsp_fault`. Only one memory request is ever outstanding. `rsp_valid` has no effect unless a probe is waiting for its answer.

Top module: `ifb_frame_builder`

## Requirements
- R1: While reset is held and right after it, `req_ready` is 1 and `mem_valid`, `upd_valid`, `done`, `err_unsup` and `err_fault` are 0.
- R2: The frame base is (`cur_rsp` - 40) with its low four bits cleared. Every memory address is this base plus a multiple of 8, and `upd_rsp` equals this base.
- R3: After a supported request is accepted, the block issues a probe (`mem_probe`=1) at base+0. Once that probe's response is clean, it issues a probe at base+32. It makes no write request before both responses have arrived without fault.
- R4: A probe response with `rsp_fault`=1 ends the sequence. `err_fault` then pulses for one cycle. No write follows, `upd_valid` stays 0, and `req_ready` returns to 1 in the next cycle.
- R5: The five writes (`mem_probe`=0) go to offsets 0, 8, 16, 24 and 32, in ascending order. They carry the return RIP, CS zero-extended, old RFLAGS, old RSP and SS zero-extended, in that order.
- R6: While `mem_valid` is 1 and `mem_ready` is 0, `mem_probe`, `mem_addr` and `mem_data` hold their values into the next cycle.
- R7: `upd_valid` is a one-cycle pulse in the cycle after the fifth write is accepted. With it, `upd_cs` is the gate selector, `upd_rip` the gate offset and `upd_ss` the old SS.
- R8: `upd_rflags` has bit 8 (trace), bit 14 (nested task) and bit 16 (resume) cleared. All bits other than 8, 9, 14 and 16 equal the old RFLAGS.
- R9: Bit 9 (interrupt enable) of `upd_rflags` is 0 when `gate_trap`=0 (interrupt gate). When `gate_trap`=1 (trap gate) it keeps its old value.
- R10: A request with `ist_idx` nonzero or `priv_chg`=1 produces a one-cycle `err_unsup` pulse in the cycle after acceptance and no memory request. `req_ready` returns to 1 in the next cycle.
- R11: `done` pulses for one cycle right after `upd_valid`. `req_ready` is 1 only when no sequence is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted when both high |
| gate_sel | input | SEL_W | Gate target code selector |
| gate_off | input | DATA_W | Gate target offset |
| gate_trap | input | 1 | Lowest gate type bit, 1 = trap gate |
| ist_idx | input | IST_W | Interrupt stack table index from gate, nonzero = switch |
| priv_chg | input | 1 | Privilege level would change |
| ret_rip | input | DATA_W | Return RIP to save |
| cur_cs | input | SEL_W | Current CS selector |
| cur_ss | input | SEL_W | Current SS selector |
| cur_rsp | input | DATA_W | Current RSP |
| cur_rflags | input | DATA_W | Current RFLAGS |
| mem_valid | output | 1 | Memory request present |
| mem_ready | input | 1 | Memory request accepted |
| mem_probe | output | 1 | 1 = access probe, 0 = write |
| mem_addr | output | DATA_W | Byte address of the quadword |
| mem_data | output | DATA_W | Write data |
| rsp_valid | input | 1 | Probe response present |
| rsp_fault | input | 1 | Probe found the address inaccessible |
| upd_valid | output | 1 | New register values present |
| upd_rsp | output | DATA_W | New RSP |
| upd_ss | output | SEL_W | New SS selector |
| upd_cs | output | SEL_W | New CS selector |
| upd_rip | output | DATA_W | New RIP |
| upd_rflags | output | DATA_W | New RFLAGS |
| done | output | 1 | Sequence completed |
| err_unsup | output | 1 | Stack switch requested, refused |
| err_fault | output | 1 | Probe faulted, sequence abandoned |

## Verification
Some properties are checked by assertions on every cycle. These are: request stability under back-pressure, the quadword alignment of every address, the cleared trace, nested-task and resume bits on each update, done following the update, the mutual exclusion of the result pulses, and the return to idle after a refusal. Other behaviour can only be shown by the bench's scenarios against its reference model. That covers the exact base arithmetic for unaligned and aligned stack pointers, the probe-then-write ordering and slot contents, the interrupt-enable rule for both gate kinds, and the absence of writes after a fault on either probe.

// File: rtl/ifb_pkg.sv
package ifb_pkg;
  localparam int FRAME_SLOTS = 5;
  localparam int SLOT_RIP    = 0;
  localparam int SLOT_CS     = 1;
  localparam int SLOT_FLAGS  = 2;
  localparam int SLOT_SP     = 3;
  localparam int SLOT_SS     = 4;
  localparam int TF_BIT      = 8;
  localparam int IF_BIT      = 9;
  localparam int NT_BIT      = 14;
  localparam int RF_BIT      = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PROBE, ST_PWAIT, ST_WRITE,
    ST_COMMIT, ST_DONE, ST_UNSUP, ST_ABORT
  } seq_st_e;
endpackage

// File: rtl/ifb_addr_gen.sv
module ifb_addr_gen #(
  parameter int DATA_W      = 64,
  parameter int ALIGN_BYTES = 16,
  parameter int IDX_W       = 3
) (
  input  logic [DATA_W-1:0] rsp,
  input  logic              probe,
  input  logic              probe_hi,
  input  logic [IDX_W-1:0]  slot_idx,
  output logic [DATA_W-1:0] base,
  output logic [DATA_W-1:0] addr
);
  import ifb_pkg::*;
  localparam int SLOT_BYTES  = DATA_W / 8;
  localparam int FRAME_BYTES = FRAME_SLOTS * SLOT_BYTES;
  localparam int LAST_OFF    = (FRAME_SLOTS - 1) * SLOT_BYTES;

  logic [DATA_W-1:0] lowered;
  logic [DATA_W-1:0] offset;

  assign lowered = rsp - DATA_W'(FRAME_BYTES);
  assign base    = lowered & ~DATA_W'(ALIGN_BYTES - 1);

  always_comb begin
    if (probe) offset = probe_hi ? DATA_W'(LAST_OFF) : '0;
    else       offset = DATA_W'(slot_idx) * DATA_W'(SLOT_BYTES);
  end

  assign addr = base + offset;
endmodule

// File: rtl/ifb_slot_mux.sv
module ifb_slot_mux #(
  parameter int DATA_W = 64,
  parameter int SLOTS  = 5,
  parameter int IDX_W  = 3
) (
  input  logic [SLOTS*DATA_W-1:0] slots_flat,
  input  logic [IDX_W-1:0]        sel,
  output logic [DATA_W-1:0]       data
);
  logic [DATA_W-1:0] part [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign part[g] = (sel == IDX_W'(g)) ? slots_flat[g*DATA_W +: DATA_W] : '0;
  end

  always_comb begin
    data = '0;
    for (int i = 0; i < SLOTS; i++) data = data | part[i];
  end
endmodule

// File: rtl/ifb_flag_edit.sv
module ifb_flag_edit #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] old_flags,
  input  logic              trap_gate,
  output logic [DATA_W-1:0] new_flags
);
  import ifb_pkg::*;
  always_comb begin
    new_flags         = old_flags;
    new_flags[TF_BIT] = 1'b0;
    new_flags[NT_BIT] = 1'b0;
    new_flags[RF_BIT] = 1'b0;
    if (!trap_gate) new_flags[IF_BIT] = 1'b0;
  end
endmodule

// File: rtl/ifb_seq.sv
module ifb_seq #(
  parameter int SLOTS = 5,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             unsup,
  input  logic             mem_ready,
  input  logic             rsp_valid,
  input  logic             rsp_fault,
  output logic             req_ready,
  output logic             accept,
  output logic             mem_valid,
  output logic             mem_probe,
  output logic             probe_hi,
  output logic [IDX_W-1:0] slot_idx,
  output logic             upd_valid,
  output logic             done,
  output logic             err_unsup,
  output logic             err_fault
);
  import ifb_pkg::*;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLOTS - 1);

  seq_st_e st_q;

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign mem_valid = (st_q == ST_PROBE) || (st_q == ST_WRITE);
  assign mem_probe = (st_q == ST_PROBE);
  assign upd_valid = (st_q == ST_COMMIT);
  assign done      = (st_q == ST_DONE);
  assign err_unsup = (st_q == ST_UNSUP);
  assign err_fault = (st_q == ST_ABORT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      probe_hi <= 1'b0;
      slot_idx <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (accept) begin
          st_q     <= unsup ? ST_UNSUP : ST_PROBE;
          probe_hi <= 1'b0;
          slot_idx <= '0;
        end
        ST_PROBE: if (mem_ready) st_q <= ST_PWAIT;
        ST_PWAIT: if (rsp_valid) begin
          if (rsp_fault)     st_q <= ST_ABORT;
          else if (probe_hi) st_q <= ST_WRITE;
          else begin
            probe_hi <= 1'b1;
            st_q     <= ST_PROBE;
          end
        end
        ST_WRITE: if (mem_ready) begin
          if (slot_idx == LAST_IDX) st_q <= ST_COMMIT;
          else slot_idx <= slot_idx + 1'b1;
        end
        ST_COMMIT: st_q <= ST_DONE;
        default:   st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ifb_frame_builder.sv
module ifb_frame_builder #(
  parameter int DATA_W      = 64,
  parameter int SEL_W       = 16,
  parameter int IST_W       = 3,
  parameter int ALIGN_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SEL_W-1:0]  gate_sel,
  input  logic [DATA_W-1:0] gate_off,
  input  logic              gate_trap,
  input  logic [IST_W-1:0]  ist_idx,
  input  logic              priv_chg,
  input  logic [DATA_W-1:0] ret_rip,
  input  logic [SEL_W-1:0]  cur_cs,
  input  logic [SEL_W-1:0]  cur_ss,
  input  logic [DATA_W-1:0] cur_rsp,
  input  logic [DATA_W-1:0] cur_rflags,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_probe,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  input  logic              rsp_valid,
  input  logic              rsp_fault,
  output logic              upd_valid,
  output logic [DATA_W-1:0] upd_rsp,
  output logic [SEL_W-1:0]  upd_ss,
  output logic [SEL_W-1:0]  upd_cs,
  output logic [DATA_W-1:0] upd_rip,
  output logic [DATA_W-1:0] upd_rflags,
  output logic              done,
  output logic              err_unsup,
  output logic              err_fault
);
  import ifb_pkg::*;
  localparam int IDX_W = $clog2(FRAME_SLOTS);

  logic              accept, probe_hi, unsup;
  logic [IDX_W-1:0]  slot_idx;
  logic [SEL_W-1:0]  sel_q, cs_q, ss_q;
  logic [DATA_W-1:0] off_q, rip_q, rsp_q, flags_q, base;
  logic              trap_q;
  logic [FRAME_SLOTS*DATA_W-1:0] slots_flat;

  assign unsup = (ist_idx != '0) || priv_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0; cs_q <= '0; ss_q <= '0; trap_q <= 1'b0;
      off_q <= '0; rip_q <= '0; rsp_q <= '0; flags_q <= '0;
    end else if (accept) begin
      sel_q   <= gate_sel;
      off_q   <= gate_off;
      trap_q  <= gate_trap;
      rip_q   <= ret_rip;
      cs_q    <= cur_cs;
      ss_q    <= cur_ss;
      rsp_q   <= cur_rsp;
      flags_q <= cur_rflags;
    end
  end

  ifb_seq #(.SLOTS(FRAME_SLOTS), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .unsup(unsup),
    .mem_ready(mem_ready), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .req_ready(req_ready), .accept(accept), .mem_valid(mem_valid),
    .mem_probe(mem_probe), .probe_hi(probe_hi), .slot_idx(slot_idx),
    .upd_valid(upd_valid), .done(done), .err_unsup(err_unsup),
    .err_fault(err_fault)
  );

  ifb_addr_gen #(.DATA_W(DATA_W), .ALIGN_BYTES(ALIGN_BYTES), .IDX_W(IDX_W)) u_addr (
    .rsp(rsp_q), .probe(mem_probe), .probe_hi(probe_hi),
    .slot_idx(slot_idx), .base(base), .addr(mem_addr)
  );

  assign slots_flat[SLOT_RIP*DATA_W   +: DATA_W] = rip_q;
  assign slots_flat[SLOT_CS*DATA_W    +: DATA_W] = DATA_W'(cs_q);
  assign slots_flat[SLOT_FLAGS*DATA_W +: DATA_W] = flags_q;
  assign slots_flat[SLOT_SP*DATA_W    +: DATA_W] = rsp_q;
  assign slots_flat[SLOT_SS*DATA_W    +: DATA_W] = DATA_W'(ss_q);

  ifb_slot_mux #(.DATA_W(DATA_W), .SLOTS(FRAME_SLOTS), .IDX_W(IDX_W)) u_mux (
    .slots_flat(slots_flat), .sel(slot_idx), .data(mem_data)
  );

  ifb_flag_edit #(.DATA_W(DATA_W)) u_flags (
    .old_flags(flags_q), .trap_gate(trap_q), .new_flags(upd_rflags)
  );

  assign upd_rsp = base;
  assign upd_ss  = ss_q;
  assign upd_cs  = sel_q;
  assign upd_rip = off_q;
endmodule

// File: rtl/ifb_frame_builder_chk.sv
module ifb_frame_builder_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_probe,
  input logic [DATA_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_data,
  input logic              upd_valid,
  input logic [DATA_W-1:0] upd_rflags,
  input logic              done,
  input logic              err_unsup,
  input logic              err_fault
);
  assert_hold_under_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_probe) &&
                                   $stable(mem_addr) && $stable(mem_data)));

  assert_quad_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_addr[2:0] == 3'b000));

  assert_flags_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> (!upd_rflags[8] && !upd_rflags[14] && !upd_rflags[16]));

  assert_done_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> done);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_valid);

  assert_fault_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_fault, err_unsup, upd_valid, done}));

  assert_unsup_returns_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_unsup |=> req_ready);
endmodule

bind ifb_frame_builder ifb_frame_builder_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .mem_valid(mem_valid),
  .mem_ready(mem_ready), .mem_probe(mem_probe), .mem_addr(mem_addr),
  .mem_data(mem_data), .upd_valid(upd_valid), .upd_rflags(upd_rflags),
  .done(done), .err_unsup(err_unsup), .err_fault(err_fault)
);

// File: tb/ifb_frame_builder_tb.sv
`timescale 1ns/1ps
module ifb_frame_builder_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic req_valid = 0, req_ready, gate_trap = 0, priv_chg = 0;
  logic [15:0] gate_sel = 0, cur_cs = 0, cur_ss = 0, upd_ss, upd_cs;
  logic [63:0] gate_off = 0, ret_rip = 0, cur_rsp = 0, cur_rflags = 0;
  logic [2:0]  ist_idx = 0;
  logic mem_valid, mem_ready = 0, mem_probe, rsp_valid = 0, rsp_fault = 0;
  logic [63:0] mem_addr, mem_data, upd_rsp, upd_rip, upd_rflags;
  logic upd_valid, done, err_unsup, err_fault;

  ifb_frame_builder u_dut (.*);

  int n_cmp = 0, n_bad = 0, cycles = 0;
  int ready_pct = 100, lat = 0, fault_sel = 0;
  bit q_go = 0;
  bit [15:0] q_sel, q_cs, q_ss; bit [63:0] q_off, q_rip, q_rsp, q_fl;
  bit q_trap, q_priv; bit [2:0] q_ist;
  // reference model state
  int m_ph = 0, m_k = 0;
  bit [63:0] m_sp, m_frame[5], m_off, m_fl_exp; bit [15:0] m_sel, m_ss;
  bit pend = 0; int pcnt = 0; bit [63:0] paddr;

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit [63:0] exp_addr();
    if (m_ph == 1) return m_sp + (m_k == 1 ? 64'd32 : 64'd0);
    return m_sp + 64'(m_k * 8);
  endfunction

  always @(negedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_bad++; $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
    if (rst_n) begin
      // compare DUT against model state for this cycle
      chk(req_ready == (m_ph == 0), "R11 req_ready", 64'(req_ready), 64'(m_ph == 0));
      chk(mem_valid == (m_ph == 1 || m_ph == 3), "R3 mem_valid", 64'(mem_valid), 64'(m_ph == 1 || m_ph == 3));
      if (m_ph == 1 || m_ph == 3) begin
        chk(mem_probe == (m_ph == 1), "R3 mem_probe kind", 64'(mem_probe), 64'(m_ph == 1));
        chk(mem_addr == exp_addr(), m_ph == 1 ? "R3 probe addr" : "R2 write addr", mem_addr, exp_addr());
        if (m_ph == 3) chk(mem_data == m_frame[m_k], "R5/R6 write data", mem_data, m_frame[m_k]);
      end
      chk(upd_valid == (m_ph == 4), "R7 upd_valid", 64'(upd_valid), 64'(m_ph == 4));
      if (m_ph == 4) begin
        chk(upd_rsp == m_sp, "R2 upd_rsp", upd_rsp, m_sp);
        chk(upd_cs == m_sel, "R7 upd_cs", 64'(upd_cs), 64'(m_sel));
        chk(upd_rip == m_off, "R7 upd_rip", upd_rip, m_off);
        chk(upd_ss == m_ss, "R7 upd_ss", 64'(upd_ss), 64'(m_ss));
        chk(upd_rflags == m_fl_exp, "R8/R9 upd_rflags", upd_rflags, m_fl_exp);
      end
      chk(done == (m_ph == 5), "R11 done", 64'(done), 64'(m_ph == 5));
      chk(err_unsup == (m_ph == 6), "R10 err_unsup", 64'(err_unsup), 64'(m_ph == 6));
      chk(err_fault == (m_ph == 7), "R4 err_fault", 64'(err_fault), 64'(m_ph == 7));
    end
    // drive inputs for next edge
    rsp_valid = 0; rsp_fault = 0;
    if (pend) begin
      if (pcnt == 0) begin
        rsp_valid = 1; pend = 0;
        rsp_fault = (fault_sel == 1 && paddr == m_sp) || (fault_sel == 2 && paddr == m_sp + 64'd32);
      end else pcnt--;
    end
    mem_ready = (($urandom % 100) < ready_pct);
    if (mem_valid && mem_ready && mem_probe) begin pend = 1; pcnt = lat; paddr = mem_addr; end
    req_valid = q_go && rst_n;
    gate_sel = q_sel; gate_off = q_off; gate_trap = q_trap; ist_idx = q_ist; priv_chg = q_priv;
    ret_rip = q_rip; cur_cs = q_cs; cur_ss = q_ss; cur_rsp = q_rsp; cur_rflags = q_fl;
    // model transition at the coming edge
    if (rst_n) begin
      case (m_ph)
        0: if (req_valid) begin
          q_go = 0;
          m_sp = (q_rsp - 64'd40) & ~64'hF;
          m_frame[0] = q_rip; m_frame[1] = {48'd0, q_cs}; m_frame[2] = q_fl;
          m_frame[3] = q_rsp; m_frame[4] = {48'd0, q_ss};
          m_sel = q_sel; m_off = q_off; m_ss = q_ss;
          m_fl_exp = q_fl & ~((64'd1 << 8) | (64'd1 << 14) | (64'd1 << 16));
          if (!q_trap) m_fl_exp[9] = 1'b0;
          m_k = 0;
          m_ph = (q_ist != 0 || q_priv) ? 6 : 1;
        end
        1: if (mem_ready) m_ph = 2;
        2: if (rsp_valid) begin
          if (rsp_fault) m_ph = 7;
          else if (m_k == 1) begin m_ph = 3; m_k = 0; end
          else begin m_k = 1; m_ph = 1; end
        end
        3: if (mem_ready) begin if (m_k == 4) m_ph = 4; else m_k++; end
        4: m_ph = 5;
        default: m_ph = 0;
      endcase
    end
  end

  task automatic run(bit [63:0] rsp, bit [63:0] fl, bit trap, bit [2:0] ist, bit priv,
                     int rdy, int l, int fsel);
    @(negedge clk);
    ready_pct = rdy; lat = l; fault_sel = fsel;
    q_sel = 16'h0010 + 16'(rsp[7:0]); q_off = 64'hFFFF_8000_0000_1000 ^ rsp;
    q_trap = trap; q_ist = ist; q_priv = priv;
    q_rip = 64'h0000_7FFF_1234_5678 + rsp; q_cs = 16'h0033; q_ss = 16'h002B;
    q_rsp = rsp; q_fl = fl; q_go = 1;
    do @(negedge clk); while (q_go || m_ph != 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(req_ready === 1'b1, "R1 reset req_ready", 64'(req_ready), 64'd1);
    chk(mem_valid === 1'b0, "R1 reset mem_valid", 64'(mem_valid), 64'd0);
    chk({upd_valid, done, err_unsup, err_fault} === 4'b0, "R1 reset pulses",
        64'({upd_valid, done, err_unsup, err_fault}), 64'd0);
    rst_n = 1;
    run(64'h0000_7FFF_FFFF_E008, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 0, 100, 0, 0); // R9 trap keeps IF
    run(64'h0000_7FFF_FFFF_1237, 64'h0000_0000_0001_4346, 0, 0, 0, 40, 3, 0);  // R9 interrupt gate
    run(64'h0000_0000_0000_1000, 64'h0000_0000_0000_0002, 1, 0, 0, 60, 1, 0);  // R2 aligned input
    run(64'h0000_0000_0000_5000, 64'h0000_0000_0000_0202, 0, 3'd3, 0, 100, 0, 0); // R10 IST
    run(64'h0000_0000_0000_6000, 64'h0000_0000_0000_0202, 0, 0, 1, 100, 0, 0); // R10 privilege
    run(64'h0000_0000_0000_7010, 64'h0000_0000_0000_0302, 0, 0, 0, 70, 2, 1); // R4 first probe
    run(64'h0000_0000_0000_8020, 64'h0000_0000_0000_0302, 1, 0, 0, 50, 0, 2); // R4 second probe
    run(64'h0000_0000_0000_9abc, 64'h0000_0000_0001_4102, 1, 0, 0, 30, 4, 0); // R9 trap IF clear
    run(64'h0000_0000_0000_0028, 64'h0000_0000_0000_0302, 0, 0, 0, 100, 0, 0); // R2 base zero
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule